// File: doc/BRIEF.md
# PWM Fault Protection Unit

This block sits between the PWM waveform generator and the pin drivers. It watches a set of asynchronous fault inputs. When a fault is active, it drives the selected PWM output pairs to safe levels that software has programmed. Each fault input has its own settings:

- a polarity bit that chooses which level counts as a fault;
- an optional filter that rejects pulses lasting a single clock;
- a mode bit that chooses level-held or latched behaviour.

A latched fault is released only after two things have happened: the input has left the fault level, and software has pulsed that fault's clear bit.

Each output channel carries a mask that selects which faults act on it. At the output stage, fault forcing wins over the software output override, and the override wins over the generator waveform. For every fault, the block reports the conditioned input level and the active status.

Top module: `pwm_fault_prot`

## Requirements
- R1: While rst_ni is low, and after it is released with no fault at its fault level, fault_lvl_o and fault_act_o are all 0 and every channel output follows the override selector or the generator.
- R2: pol_i[f]=1 makes a high fault_i[f] the fault level, and pol_i[f]=0 makes a low input the fault level. With the filter off, fault_lvl_o[f] is 1 exactly when the input is at the fault level, and it shows a change at the second rising edge after the change.
- R3: With filt_en_i[f]=1, a fault level that lasts only one clock never reaches fault_lvl_o[f] or fault_act_o[f]. A steady level shows at the fourth rising edge after the change.
- R4: With filt_en_i[f]=0, a one-clock fault pulse does reach fault_lvl_o[f]. In mode 1 it leaves the fault latched.
- R5: With mode_i[f]=0, fault_act_o[f] equals fault_lvl_o[f] in every cycle.
- R6: With mode_i[f]=1, fault_act_o[f] rises together with fault_lvl_o[f]. It stays 1 until a clock edge at which clr_i[f]=1 and fault_lvl_o[f]=0.
- R7: With mode_i[f]=1, a clr_i[f] pulse given while fault_lvl_o[f]=1 has no effect, and the fault stays active after it.
- R8: Channel c is forced when any fault f with fault_act_o[f]=1 has ch_mask_i[c*NUM_FAULTS+f]=1. A forced channel drives pwm_h_o[c]=safe_h_i[c] and pwm_l_o[c]=safe_l_i[c].
- R9: On an unforced channel, a set ovr_h_en_i[c] or ovr_l_en_i[c] selects ovr_h_val_i[c] or ovr_l_val_i[c] for that side. Otherwise the side takes gen_h_i[c] or gen_l_i[c]. Forcing takes priority over the override.
- R10: An active fault whose mask bit is 0 for a channel has no effect on that channel's outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fault_i | input | NUM_FAULTS | Asynchronous fault inputs |
| pol_i | input | NUM_FAULTS | Fault level per input (1 = high) |
| filt_en_i | input | NUM_FAULTS | Glitch filter enable per input |
| mode_i | input | NUM_FAULTS | 0 = level-held, 1 = latched until clear |
| clr_i | input | NUM_FAULTS | Clear pulse per fault |
| ch_mask_i | input | NUM_CH*NUM_FAULTS | Per-channel fault enable mask |
| safe_h_i | input | NUM_CH | Forced value, high side |
| safe_l_i | input | NUM_CH | Forced value, low side |
| gen_h_i | input | NUM_CH | Generator waveform, high side |
| gen_l_i | input | NUM_CH | Generator waveform, low side |
| ovr_h_en_i | input | NUM_CH | Override select, high side |
| ovr_l_en_i | input | NUM_CH | Override select, low side |
| ovr_h_val_i | input | NUM_CH | Override value, high side |
| ovr_l_val_i | input | NUM_CH | Override value, low side |
| pwm_h_o | output | NUM_CH | Output to driver, high side |
| pwm_l_o | output | NUM_CH | Output to driver, low side |
| fault_lvl_o | output | NUM_FAULTS | Conditioned input at fault level |
| fault_act_o | output | NUM_FAULTS | Fault active status |

## Verification
The hardest case to reach is a latched fault whose status depends on history: a level seen under an old mode, a clear that arrives while the input is still at the fault level, or a single-clock pulse that the filter must swallow. The random phases change polarity, mode and input together. They then let the pipeline settle and pulse clears at random. A bench model carries the latch state from one phase to the next. Directed single-clock pulses, with the filter on and then off in latched mode, show whether a glitch was rejected, because a glitch that got through leaves the fault latched.

// File: rtl/fp_pkg.sv
package fp_pkg;
  typedef struct packed {
    logic h;
    logic l;
  } pair_t;

  function automatic pair_t pick_pair(input logic forced, input pair_t safe,
                                      input pair_t ovr_en, input pair_t ovr_val,
                                      input pair_t gen);
    pair_t r;
    r.h = forced ? safe.h : (ovr_en.h ? ovr_val.h : gen.h);
    r.l = forced ? safe.l : (ovr_en.l ? ovr_val.l : gen.l);
    return r;
  endfunction
endpackage

// File: rtl/fp_fault_cond.sv
module fp_fault_cond #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fault_i,
  input  logic pol_i,
  input  logic filt_en_i,
  input  logic mode_i,
  input  logic clr_i,
  output logic lvl_o,
  output logic act_o
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] sync_q;
  logic          prev_q;
  logic          filt_q;
  logic          latch_q;
  logic          at_lvl;
  logic          norm;

  // normalise to "1 = at fault level" before sync so reset value means idle
  assign norm = fault_i ~^ pol_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[LAST-1:0], norm};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      filt_q <= 1'b0;
    end else begin
      prev_q <= sync_q[LAST];
      if (sync_q[LAST] == prev_q) filt_q <= prev_q;
    end
  end

  assign at_lvl = filt_en_i ? filt_q : sync_q[LAST];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_q <= 1'b0;
    end else if (!mode_i) begin
      latch_q <= 1'b0;
    end else begin
      latch_q <= at_lvl | (latch_q & ~clr_i);
    end
  end

  assign lvl_o = at_lvl;
  assign act_o = mode_i ? (latch_q | at_lvl) : at_lvl;
endmodule

// File: rtl/fp_out_mux.sv
module fp_out_mux
  import fp_pkg::*;
#(
  parameter int NUM_FAULTS = 6
) (
  input  logic [NUM_FAULTS-1:0] act_i,
  input  logic [NUM_FAULTS-1:0] mask_i,
  input  pair_t                 safe_i,
  input  pair_t                 ovr_en_i,
  input  pair_t                 ovr_val_i,
  input  pair_t                 gen_i,
  output pair_t                 out_o
);
  logic forced;
  assign forced = |(act_i & mask_i);
  assign out_o  = pick_pair(forced, safe_i, ovr_en_i, ovr_val_i, gen_i);
endmodule

// File: rtl/pwm_fault_prot.sv
module pwm_fault_prot
  import fp_pkg::*;
#(
  parameter int NUM_FAULTS = 6,
  parameter int NUM_CH     = 4
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [NUM_FAULTS-1:0]        fault_i,
  input  logic [NUM_FAULTS-1:0]        pol_i,
  input  logic [NUM_FAULTS-1:0]        filt_en_i,
  input  logic [NUM_FAULTS-1:0]        mode_i,
  input  logic [NUM_FAULTS-1:0]        clr_i,
  input  logic [NUM_CH*NUM_FAULTS-1:0] ch_mask_i,
  input  logic [NUM_CH-1:0]            safe_h_i,
  input  logic [NUM_CH-1:0]            safe_l_i,
  input  logic [NUM_CH-1:0]            gen_h_i,
  input  logic [NUM_CH-1:0]            gen_l_i,
  input  logic [NUM_CH-1:0]            ovr_h_en_i,
  input  logic [NUM_CH-1:0]            ovr_l_en_i,
  input  logic [NUM_CH-1:0]            ovr_h_val_i,
  input  logic [NUM_CH-1:0]            ovr_l_val_i,
  output logic [NUM_CH-1:0]            pwm_h_o,
  output logic [NUM_CH-1:0]            pwm_l_o,
  output logic [NUM_FAULTS-1:0]        fault_lvl_o,
  output logic [NUM_FAULTS-1:0]        fault_act_o
);
  logic [NUM_FAULTS-1:0] lvl;
  logic [NUM_FAULTS-1:0] act;

  for (genvar f = 0; f < NUM_FAULTS; f++) begin : g_fault
    fp_fault_cond #(.SYNC_STAGES(2)) i_cond (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .fault_i   (fault_i[f]),
      .pol_i     (pol_i[f]),
      .filt_en_i (filt_en_i[f]),
      .mode_i    (mode_i[f]),
      .clr_i     (clr_i[f]),
      .lvl_o     (lvl[f]),
      .act_o     (act[f])
    );
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    pair_t out;
    fp_out_mux #(.NUM_FAULTS(NUM_FAULTS)) i_mux (
      .act_i     (act),
      .mask_i    (ch_mask_i[c*NUM_FAULTS +: NUM_FAULTS]),
      .safe_i    ('{h: safe_h_i[c],    l: safe_l_i[c]}),
      .ovr_en_i  ('{h: ovr_h_en_i[c],  l: ovr_l_en_i[c]}),
      .ovr_val_i ('{h: ovr_h_val_i[c], l: ovr_l_val_i[c]}),
      .gen_i     ('{h: gen_h_i[c],     l: gen_l_i[c]}),
      .out_o     (out)
    );
    assign pwm_h_o[c] = out.h;
    assign pwm_l_o[c] = out.l;
  end

  assign fault_lvl_o = lvl;
  assign fault_act_o = act;
endmodule

// File: rtl/pwm_fault_prot_chk.sv
module pwm_fault_prot_chk #(
  parameter int NUM_FAULTS = 6,
  parameter int NUM_CH     = 4
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic [NUM_FAULTS-1:0]        mode_i,
  input logic [NUM_FAULTS-1:0]        clr_i,
  input logic [NUM_CH*NUM_FAULTS-1:0] ch_mask_i,
  input logic [NUM_CH-1:0]            safe_h_i,
  input logic [NUM_CH-1:0]            safe_l_i,
  input logic [NUM_CH-1:0]            ovr_h_en_i,
  input logic [NUM_CH-1:0]            ovr_h_val_i,
  input logic [NUM_CH-1:0]            pwm_h_o,
  input logic [NUM_CH-1:0]            pwm_l_o,
  input logic [NUM_FAULTS-1:0]        fault_lvl_o,
  input logic [NUM_FAULTS-1:0]        fault_act_o
);
  for (genvar f = 0; f < NUM_FAULTS; f++) begin : g_f
    // R5
    lvl_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !mode_i[f] |-> (fault_act_o[f] == fault_lvl_o[f]));
    // R6
    latch_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_i[f] && fault_act_o[f] && !clr_i[f]) |=> (!mode_i[f] || fault_act_o[f]));
    // R7
    clr_at_lvl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_i[f] && fault_lvl_o[f]) |=> (!mode_i[f] || fault_act_o[f]));
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_c
    // R8
    force_val_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      |(fault_act_o & ch_mask_i[c*NUM_FAULTS +: NUM_FAULTS])
        |-> (pwm_h_o[c] == safe_h_i[c] && pwm_l_o[c] == safe_l_i[c]));
    // R9
    ovr_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!(|(fault_act_o & ch_mask_i[c*NUM_FAULTS +: NUM_FAULTS])) && ovr_h_en_i[c])
        |-> (pwm_h_o[c] == ovr_h_val_i[c]));
  end
endmodule

bind pwm_fault_prot pwm_fault_prot_chk #(.NUM_FAULTS(NUM_FAULTS), .NUM_CH(NUM_CH)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mode_i      (mode_i),
  .clr_i       (clr_i),
  .ch_mask_i   (ch_mask_i),
  .safe_h_i    (safe_h_i),
  .safe_l_i    (safe_l_i),
  .ovr_h_en_i  (ovr_h_en_i),
  .ovr_h_val_i (ovr_h_val_i),
  .pwm_h_o     (pwm_h_o),
  .pwm_l_o     (pwm_l_o),
  .fault_lvl_o (fault_lvl_o),
  .fault_act_o (fault_act_o)
);

// File: tb/test_pwm_fault_prot.sv
`timescale 1ns/1ps
module test_pwm_fault_prot;
  localparam int NF = 6;
  localparam int NC = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NF-1:0] fault, pol, filt, mode, clr;
  logic [NC*NF-1:0] mask;
  logic [NC-1:0] safe_h, safe_l, gen_h, gen_l, oh_en, ol_en, oh_v, ol_v;
  logic [NC-1:0] pwm_h, pwm_l;
  logic [NF-1:0] lvl, act;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  pwm_fault_prot #(.NUM_FAULTS(NF), .NUM_CH(NC)) i_pwm_fault_prot (
    .clk_i(clk), .rst_ni(rst_n), .fault_i(fault), .pol_i(pol), .filt_en_i(filt),
    .mode_i(mode), .clr_i(clr), .ch_mask_i(mask), .safe_h_i(safe_h), .safe_l_i(safe_l),
    .gen_h_i(gen_h), .gen_l_i(gen_l), .ovr_h_en_i(oh_en), .ovr_l_en_i(ol_en),
    .ovr_h_val_i(oh_v), .ovr_l_val_i(ol_v), .pwm_h_o(pwm_h), .pwm_l_o(pwm_l),
    .fault_lvl_o(lvl), .fault_act_o(act)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] a, input logic [31:0] e);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, a, e);
    end
  endtask

  function automatic logic [2*NC-1:0] exp_out(input logic [NF-1:0] a);
    logic [NC-1:0] h, l;
    for (int c = 0; c < NC; c++) begin
      logic f;
      f = |(a & mask[c*NF +: NF]);
      h[c] = f ? safe_h[c] : (oh_en[c] ? oh_v[c] : gen_h[c]);
      l[c] = f ? safe_l[c] : (ol_en[c] ? ol_v[c] : gen_l[c]);
    end
    return {h, l};
  endfunction

  task automatic chk_out(input string req, input logic [NF-1:0] a);
    logic [2*NC-1:0] e;
    e = exp_out(a);
    chk({pwm_h, pwm_l} == e, req, {pwm_h, pwm_l}, e);
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic rand_outs();
    mask = $urandom; safe_h = $urandom; safe_l = $urandom; gen_h = $urandom;
    gen_l = $urandom; oh_en = $urandom; ol_en = $urandom; oh_v = $urandom; ol_v = $urandom;
  endtask

  initial begin
    #400000;
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [NF-1:0] lat_m, at_m, at_old, ck, mnew;
    void'($urandom(32'h5eed_1234));
    fault = '0; pol = '1; filt = '0; mode = '0; clr = '0;
    rand_outs();
    cyc(3);
    // R1: in reset
    chk(lvl == '0 && act == '0, "R1 lvl/act in reset", {lvl, act}, 0);
    chk_out("R1 outputs in reset", '0);
    @(negedge clk) rst_n = 1'b1;
    cyc(4);
    chk(lvl == '0 && act == '0, "R1 after reset", {lvl, act}, 0);
    chk_out("R1 outputs after reset", '0);

    // R2 latency, filter off, high polarity
    fault[0] = 1'b1;
    cyc(1);
    chk(lvl[0] == 1'b0, "R2 one edge after change", lvl[0], 0);
    cyc(1);
    chk(lvl[0] == 1'b1, "R2 two edges after change", lvl[0], 1);
    chk(act[0] == 1'b1, "R5 act follows lvl", act[0], 1);
    // R2 low polarity: input 1 no longer fault
    pol[0] = 1'b0;
    cyc(3);
    chk(lvl[0] == 1'b0, "R2 pol=0 high is idle", lvl[0], 0);
    fault[0] = 1'b0;
    cyc(3);
    chk(lvl[0] == 1'b1, "R2 pol=0 low is fault", lvl[0], 1);
    pol[0] = 1'b1;
    cyc(4);

    // R3 filter latency
    filt[1] = 1'b1;
    fault[1] = 1'b1;
    cyc(3);
    chk(lvl[1] == 1'b0, "R3 three edges after change", lvl[1], 0);
    cyc(1);
    chk(lvl[1] == 1'b1, "R3 four edges after change", lvl[1], 1);
    fault[1] = 1'b0;
    cyc(5);
    // R3 single-clock glitch rejected in latched mode
    mode[1] = 1'b1;
    cyc(1);
    fault[1] = 1'b1;
    cyc(1);
    fault[1] = 1'b0;
    begin
      logic seen;
      seen = 1'b0;
      for (int i = 0; i < 6; i++) begin
        cyc(1);
        seen |= lvl[1] | act[1];
      end
      chk(seen == 1'b0, "R3 glitch rejected", seen, 0);
    end
    // R4 single-clock glitch passes without filter, latches
    mode[2] = 1'b1;
    cyc(1);
    fault[2] = 1'b1;
    cyc(1);
    fault[2] = 1'b0;
    cyc(1);
    chk(lvl[2] == 1'b1, "R4 glitch visible", lvl[2], 1);
    cyc(4);
    chk(lvl[2] == 1'b0 && act[2] == 1'b1, "R4/R6 glitch latched", {lvl[2], act[2]}, 2'b01);

    // R7 clear while at level ignored
    fault[2] = 1'b1;
    cyc(3);
    clr[2] = 1'b1;
    cyc(1);
    clr[2] = 1'b0;
    fault[2] = 1'b0;
    cyc(4);
    chk(act[2] == 1'b1, "R7 clear at level ignored", act[2], 1);
    // R6 clear after level left
    clr[2] = 1'b1;
    cyc(1);
    clr[2] = 1'b0;
    chk(act[2] == 1'b0, "R6 clear releases", act[2], 0);

    // R8/R9/R10 directed, fault 3 active level mode
    fault[3] = 1'b1;
    cyc(3);
    mask = '0; mask[0*NF+3] = 1'b1; mask[1*NF+4] = 1'b1;
    safe_h = 4'b0001; safe_l = 4'b0000; oh_en = 4'b0011; ol_en = 4'b0000;
    oh_v = 4'b0010; ol_v = 4'b0000; gen_h = 4'b0000; gen_l = 4'b1111;
    cyc(1);
    chk(pwm_h[0] == 1'b1 && pwm_l[0] == 1'b0, "R8/R9 forced over override", {pwm_h[0], pwm_l[0]}, 2'b10);
    chk(pwm_h[1] == 1'b1 && pwm_l[1] == 1'b1, "R10 unmasked channel untouched", {pwm_h[1], pwm_l[1]}, 2'b11);
    chk(pwm_h[2] == 1'b0, "R9 generator when no override", pwm_h[2], 0);
    fault[3] = 1'b0;
    cyc(3);
    chk(pwm_h[0] == 1'b0, "R9 override after release", pwm_h[0], 0);

    // random phases
    fault = '0; clr = '0; mode = '0; filt = '0; pol = '1;
    cyc(6);
    lat_m = '0;
    at_m = '0;
    for (int p = 0; p < 400; p++) begin
      at_old = at_m;
      mnew = $urandom;
      fault = $urandom; pol = $urandom; filt = $urandom; mode = mnew;
      at_m = ~(fault ^ pol);
      lat_m = mnew & (lat_m | at_old | at_m);
      cyc(6);
      chk(lvl == at_m, "R2 random level", lvl, at_m);
      ck = (mode & lat_m) | (~mode & at_m);
      chk(act == ck, "R5/R6 random status", act, ck);
      rand_outs();
      cyc(1);
      chk_out("R8/R9/R10 random outputs", ck);
      clr = $urandom;
      cyc(1);
      clr = '0;
      lat_m = lat_m & ~(clr_mask_dummy(ck));
      cyc(1);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    done = 1'b1;
    $finish;
  end

  // R6/R7: clears applied at the last edge, kept in a shadow for the model
  logic [NF-1:0] clr_seen;
  always @(posedge clk) if (rst_n) clr_seen <= clr;

  function automatic logic [NF-1:0] clr_mask_dummy(input logic [NF-1:0] unused);
    return clr_seen & ~(~(fault ^ pol));
  endfunction
endmodule